// File: doc/BRIEF.md
# Registered Eight-Function Byte ALU

This block is a byte-wide arithmetic and logic unit with registered inputs and outputs. On each rising clock edge it captures two operands and a 3-bit operation code. During the following cycle one of eight function units works on the captured values, and a single eight-way selector picks the result. The next rising edge loads that result into the output register. A carry/borrow bit is registered with the result.

The eight functions are pass-through of A, bitwise AND, OR and XOR, addition, subtraction, two's-complement negation of A, and a logical shift of A. For a shift, the low three bits of B set the distance (one to four places) and the direction. A new operation can be issued every cycle. Each result appears at the outputs two rising edges after its operands were presented.

Top module: `alu8_top`

## Requirements
- R1: A synchronous active-high `rst` clears the operand, code and output registers, so `res_o` and `carry_o` read zero after a clock edge with `rst` high.
- R2: Operands and code sampled at edge n produce their result on `res_o`/`carry_o` after edge n+1, and the previous result stays visible until then.
- R3: Code 000 gives A, 001 gives A AND B, 010 gives A OR B, 011 gives A XOR B.
- R4: Code 100 gives the low 8 bits of A+B, with the ninth sum bit on `carry_o`.
- R5: Code 101 gives (A-B) mod 256, with `carry_o` = 1 exactly when A < B as unsigned numbers (borrow).
- R6: `carry_o` is 0 for every code other than 100 and 101.
- R7: Code 110 gives (256-A) mod 256, so 0x00 maps to 0x00 and 0x80 maps to 0x80.
- R8: Code 111 shifts A logically by B[1:0]+1 places, right when B[2]=0 and left when B[2]=1, filling with zeros.
- R9: For code 000 the value of B has no effect, and for code 111 bits B[7:3] have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all registers load on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_i | input | 8 | Operand A |
| b_i | input | 8 | Operand B, or the shift control for code 111 |
| op_i | input | 3 | Operation code |
| res_o | output | 8 | Registered result |
| carry_o | output | 1 | Registered carry (add) or borrow (subtract) |

## Verification
The case hardest to reach from the ports is the boundary between two results. Two edges separate an operand change from its result, so a check sampled one cycle early would still pass against a stale result that happens to match. The stimulus therefore issues one operation, leaves its result in the output register, and then issues a second operation whose result is different. It checks that the old value is still present after the first edge and the new value after the second. Borrow is covered by subtracting from both sides of equality. The complement chain is covered at its two degenerate inputs.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W  = 8;
    localparam int SHAMT_W = 2;
    localparam int SHCTL_W = SHAMT_W + 1;
    localparam int N_OPS   = 8;
    localparam int OP_W    = $clog2(N_OPS);

    typedef logic [DATA_W-1:0] word_t;

    typedef enum logic [OP_W-1:0] {
        OP_PASS = 3'd0,
        OP_AND  = 3'd1,
        OP_OR   = 3'd2,
        OP_XOR  = 3'd3,
        OP_ADD  = 3'd4,
        OP_SUB  = 3'd5,
        OP_NEG  = 3'd6,
        OP_SHF  = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic  carry;
        word_t value;
    } alu_res_t;

    function automatic alu_res_t mk_res(input logic c, input word_t v);
        alu_res_t r;
        r.carry = c;
        r.value = v;
        return r;
    endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] c;

    assign c[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic p;
        assign p        = a[i] ^ b[i];
        assign sum[i]   = p ^ c[i];
        assign c[i+1]   = (a[i] & b[i]) | (p & c[i]);
    end

    assign cout = c[W];
endmodule

// File: rtl/alu8_negate.sv
module alu8_negate #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    output logic [W-1:0] y
);
    // Bits up to and including the lowest set bit pass; the rest invert.
    logic [W:0] seen;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign y[i]      = a[i] ^ seen[i];
        assign seen[i+1] = seen[i] | a[i];
    end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter #(
    parameter int W  = 8,
    parameter int AW = 2
) (
    input  logic [W-1:0] a,
    input  logic [AW:0]  ctl,
    output logic [W-1:0] y
);
    // ctl[AW] = 1 selects left; distance is ctl[AW-1:0] + 1.
    logic         go_left;
    logic [W-1:0] src;
    logic [W-1:0] stage [AW+2];

    assign go_left = ctl[AW];

    for (genvar i = 0; i < W; i++) begin : g_in
        assign src[i] = go_left ? a[W-1-i] : a[i];
    end

    assign stage[0] = src;
    assign stage[1] = stage[0] >> 1;

    for (genvar k = 0; k < AW; k++) begin : g_stage
        assign stage[k+2] = ctl[k] ? (stage[k+1] >> (1 << k)) : stage[k+1];
    end

    for (genvar i = 0; i < W; i++) begin : g_out
        assign y[i] = go_left ? stage[AW+1][W-1-i] : stage[AW+1][i];
    end
endmodule

// File: rtl/alu8_top.sv
module alu8_top
    import alu8_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [OP_W-1:0]   op_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o
);
    word_t    a_q, b_q;
    alu_op_e  op_q;
    alu_res_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            op_q  <= OP_PASS;
            out_q <= '0;
        end else begin
            a_q   <= a_i;
            b_q   <= b_i;
            op_q  <= alu_op_e'(op_i);
            out_q <= sel;
        end
    end

    // Shared adder: subtract feeds inverted B with a carry-in of one.
    logic  is_sub;
    word_t b_eff, sum;
    logic  cout;

    assign is_sub = (op_q == OP_SUB);
    assign b_eff  = is_sub ? ~b_q : b_q;

    alu8_adder #(.W(DATA_W)) u_add (
        .a(a_q), .b(b_eff), .cin(is_sub), .sum(sum), .cout(cout)
    );

    word_t neg_y, shf_y;

    alu8_negate #(.W(DATA_W)) u_neg (
        .a(a_q), .y(neg_y)
    );

    alu8_shifter #(.W(DATA_W), .AW(SHAMT_W)) u_shf (
        .a(a_q), .ctl(b_q[SHCTL_W-1:0]), .y(shf_y)
    );

    // Candidate results, one per code, then the common selector.
    alu_res_t cand [N_OPS];
    alu_res_t sel;

    always_comb begin
        cand[OP_PASS] = mk_res(1'b0, a_q);
        cand[OP_AND]  = mk_res(1'b0, a_q & b_q);
        cand[OP_OR]   = mk_res(1'b0, a_q | b_q);
        cand[OP_XOR]  = mk_res(1'b0, a_q ^ b_q);
        cand[OP_ADD]  = mk_res(cout, sum);
        cand[OP_SUB]  = mk_res(~cout, sum);
        cand[OP_NEG]  = mk_res(1'b0, neg_y);
        cand[OP_SHF]  = mk_res(1'b0, shf_y);
        sel           = cand[op_q];
    end

    assign res_o   = out_q.value;
    assign carry_o = out_q.carry;
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
    import alu8_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [DATA_W-1:0] a_i,
    input logic [DATA_W-1:0] b_i,
    input logic [OP_W-1:0]   op_i,
    input logic [DATA_W-1:0] res_o,
    input logic              carry_o
);
    // Counts clean cycles since reset so that two-deep history is valid.
    logic [1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst)              run_q <= 2'd0;
        else if (run_q != 2'd2) run_q <= run_q + 2'd1;
    end

    p_logic_r3: assert property (@(posedge clk) disable iff (rst)
        (run_q == 2'd2 && $past(op_i, 2) == OP_XOR)
        |-> res_o == ($past(a_i, 2) ^ $past(b_i, 2)));

    p_pass_r9: assert property (@(posedge clk) disable iff (rst)
        (run_q == 2'd2 && $past(op_i, 2) == OP_PASS)
        |-> res_o == $past(a_i, 2));

    p_add_r4: assert property (@(posedge clk) disable iff (rst)
        (run_q == 2'd2 && $past(op_i, 2) == OP_ADD)
        |-> {carry_o, res_o} == ({1'b0, $past(a_i, 2)} + {1'b0, $past(b_i, 2)}));

    p_sub_r5: assert property (@(posedge clk) disable iff (rst)
        (run_q == 2'd2 && $past(op_i, 2) == OP_SUB)
        |-> (res_o == DATA_W'($past(a_i, 2) - $past(b_i, 2)))
            && (carry_o == ($past(a_i, 2) < $past(b_i, 2))));

    p_carry_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (run_q == 2'd2 && $past(op_i, 2) != OP_ADD && $past(op_i, 2) != OP_SUB)
        |-> !carry_o);

    p_neg_r7: assert property (@(posedge clk) disable iff (rst)
        (run_q == 2'd2 && $past(op_i, 2) == OP_NEG)
        |-> res_o == DATA_W'(-$past(a_i, 2)));

endmodule

bind alu8_top alu8_chk chk_i (
    .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .op_i(op_i),
    .res_o(res_o), .carry_o(carry_o)
);

// File: tb/alu8_top_tb_top.sv
module alu8_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] a_i = '0;
    logic [7:0] b_i = '0;
    logic [2:0] op_i = '0;
    logic [7:0] res_o;
    logic       carry_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    alu8_top dut_i (
        .clk(clk), .rst(rst), .a_i(a_i), .b_i(b_i), .op_i(op_i),
        .res_o(res_o), .carry_o(carry_o)
    );

    function automatic logic [8:0] model(input logic [7:0] a, input logic [7:0] b,
                                         input logic [2:0] op);
        int amt;
        case (op)
            3'd0: return {1'b0, a};
            3'd1: return {1'b0, a & b};
            3'd2: return {1'b0, a | b};
            3'd3: return {1'b0, a ^ b};
            3'd4: return {1'b0, a} + {1'b0, b};
            3'd5: return {(a < b) ? 1'b1 : 1'b0, 8'(a - b)};
            3'd6: return {1'b0, 8'(9'd256 - {1'b0, a})};
            default: begin
                amt = int'(b[1:0]) + 1;
                return {1'b0, b[2] ? 8'(a << amt) : 8'(a >> amt)};
            end
        endcase
    endfunction

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one operation and check its result two edges later.
    task automatic run_op(input string req, input logic [7:0] a, input logic [7:0] b,
                          input logic [2:0] op);
        @(negedge clk);
        a_i = a; b_i = b; op_i = op;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(req, {carry_o, res_o}, model(a, b, op));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check("R1 power-up", {carry_o, res_o}, 9'h000);
        rst = 1'b0;
        run_op("R4 pre-reset add", 8'hFF, 8'hFF, 3'd4);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid-run", {carry_o, res_o}, 9'h000);
        rst = 1'b0;
    endtask

    task automatic t_logic();
        run_op("R3 pass", 8'hA5, 8'h0F, 3'd0);
        run_op("R3 and",  8'hA5, 8'h0F, 3'd1);
        run_op("R3 or",   8'hA5, 8'h0F, 3'd2);
        run_op("R3 xor",  8'hA5, 8'h0F, 3'd3);
        run_op("R3 and2", 8'h3C, 8'hF0, 3'd1);
        run_op("R6 xor carry", 8'hFF, 8'hFF, 3'd3);
    endtask

    task automatic t_arith();
        run_op("R4 add small", 8'h12, 8'h34, 3'd4);
        run_op("R4 add wrap",  8'hFF, 8'h01, 3'd4);
        run_op("R4 add carry", 8'hC0, 8'h80, 3'd4);
        run_op("R5 sub no borrow", 8'h07, 8'h05, 3'd5);
        run_op("R5 sub borrow",    8'h05, 8'h07, 3'd5);
        run_op("R5 sub equal",     8'h5A, 8'h5A, 3'd5);
        run_op("R5 sub zero-max",  8'h00, 8'hFF, 3'd5);
    endtask

    task automatic t_negate();
        run_op("R7 neg zero", 8'h00, 8'h00, 3'd6);
        run_op("R7 neg msb",  8'h80, 8'h00, 3'd6);
        run_op("R7 neg even", 8'h90, 8'hFF, 3'd6);
        run_op("R7 neg odd",  8'h91, 8'h00, 3'd6);
        run_op("R6 neg carry", 8'h01, 8'hFF, 3'd6);
    endtask

    task automatic t_shift();
        for (int c = 0; c < 8; c++) begin
            run_op("R8 shift", 8'hB7, 8'(c), 3'd7);
        end
        run_op("R8 shift right four", 8'hF0, 8'h03, 3'd7);
        run_op("R8 shift left four",  8'h0F, 8'h07, 3'd7);
    endtask

    task automatic t_ignore();
        run_op("R9 pass b=00", 8'h3C, 8'h00, 3'd0);
        check("R9 pass value", {carry_o, res_o}, 9'h03C);
        run_op("R9 pass b=ff", 8'h3C, 8'hFF, 3'd0);
        check("R9 pass value b=ff", {carry_o, res_o}, 9'h03C);
        run_op("R9 shift hi bits", 8'h81, 8'hF9, 3'd7);
        check("R9 shift hi bits value", {carry_o, res_o}, {1'b0, 8'h81 >> 2});
    endtask

    task automatic t_latency();
        run_op("R2 first", 8'h11, 8'h00, 3'd0);
        @(negedge clk);
        a_i = 8'h22; b_i = 8'h33; op_i = 3'd4;
        @(posedge clk);
        @(negedge clk);
        check("R2 old result held", {carry_o, res_o}, 9'h011);
        @(posedge clk);
        @(negedge clk);
        check("R2 new result", {carry_o, res_o}, 9'h055);
    endtask

    initial begin
        t_reset();
        t_logic();
        t_arith();
        t_negate();
        t_shift();
        t_ignore();
        t_latency();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule